// File: doc/BRIEF.md
# Per-Application Hit-Gap Limit Predictor

This block sits beside the tag and age arrays of a shared last-level cache. The cache has several applications, and each application has its own eviction chain. The block learns, for each application, how long a line may go without a reference before it becomes a preferred victim. That span is the hit-gap limit.

The cache reports every hit as an event that carries the requesting application and the age the hit line had reached. The block keeps the largest such age per application. Time is cut into windows of a fixed number of cache misses. When a window closes, each application's limit is set to one more than the largest age it saw. An application that saw no hit is given the longest possible limit. If it stays silent, its limit flips between zero and the maximum on each following window, so a thrashing program cannot pin lines in the cache forever but still gets a chance to recover.

A lookup port serves the victim-search logic. It takes an application id and a set index and returns the limit that applies to that line. A small fixed group of sampling sets always receives the maximum limit. Those sets learn true reuse spans that the normal sets would cut short.

Top module: `hitgap_predictor`

## Requirements
- R1: While `rst_i` is high, and at the first cycle after it falls, every application's limit on `limit_vec_o` is all ones (2^AGE_W−1), and no application is treated as having missed a previous window.
- R2: A hit event (`hit_valid_i` high, `hit_app_i` = i) raises application i's running peak to `hit_age_i` when that age is larger than the peak. Smaller ages leave the peak as it is. Hits from sampling sets and normal sets count alike. If i had any hit in a window, its limit after that window is its peak + 1.
- R3: The peak + 1 of R2 saturates at 2^AGE_W−1.
- R4: If application i had no hit in a window, and the window before it had a hit (or reset came before it), i's next limit is 2^AGE_W−1.
- R5: Each further window in a row without a hit for i sets its limit to 0, then to 2^AGE_W−1, then to 0, and so on. A single hit ends the alternation.
- R6: A window closes on every 2^MISS_W-th cycle with `miss_i` high, counted from reset, whatever the gaps between misses. Limits change only in the cycle after a closing miss.
- R7: Hit events for one application never change another application's peak or limit.
- R8: A set is a sampling set when bits [SET_W−1 -: MON_W] of `lkp_set_i` equal bits [MON_W−1:0]. For a sampling set, `lkp_monitor_o` is 1 and `lkp_limit_o` is 2^AGE_W−1. Otherwise `lkp_monitor_o` is 0 and `lkp_limit_o` is the current limit of `lkp_app_i`.
- R9: A hit in the same cycle as the closing miss belongs to the window that is closing. The next window starts with every peak at zero and no hits recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| miss_i | input | 1 | One cache miss this cycle |
| hit_valid_i | input | 1 | Hit event this cycle |
| hit_app_i | input | APP_W | Application of the hit |
| hit_age_i | input | AGE_W | Age of the hit line at the hit |
| lkp_app_i | input | APP_W | Application of the line under victim search |
| lkp_set_i | input | SET_W | Set index of the line under victim search |
| lkp_limit_o | output | AGE_W | Limit that applies to the looked-up line |
| lkp_monitor_o | output | 1 | Looked-up set is a sampling set |
| limit_vec_o | output | NUM_APPS*AGE_W | Current limit of every application, application 0 in the low bits |

## Verification
A directed sequence uses four applications with different habits. One hits at mixed ages, one hits near the top of the age range, one hits exactly at the top, and one never hits. These separate the peak + 1 rule, saturation, and the first silent window from the zero/maximum flip. A hit placed on the closing miss shows whether boundary hits are counted in the window that closes. Misses spaced with idle gaps show that windows count misses, not cycles. A long random run then mixes hits, misses and lookups into every set, so that starvation streaks, recoveries and sampling-set lookups overlap.

// File: rtl/hgp_pkg.sv
package hgp_pkg;
   // Starvation phase of one application across window boundaries.
   typedef enum logic [1:0] {
      PH_FED      = 2'd0,   // last window had a hit, or fresh from reset
      PH_DRY_ZERO = 2'd1,   // silent streak: next silent window gives 0
      PH_DRY_MAX  = 2'd2    // silent streak: next silent window gives max
   } dry_ph_t;
endpackage

// File: rtl/hgp_interval_timer.sv
module hgp_interval_timer #(
   parameter int MISS_W = 12
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic miss_i,
   output logic ivl_end_o
);
   logic [MISS_W-1:0] cnt_q;

   assign ivl_end_o = miss_i && (&cnt_q);

   always_ff @(posedge clk_i) begin
      if (rst_i)       cnt_q <= '0;
      else if (miss_i) cnt_q <= cnt_q + MISS_W'(1);
   end
endmodule

// File: rtl/hgp_monitor_decode.sv
module hgp_monitor_decode #(
   parameter int SET_W = 12,
   parameter int MON_W = 5
) (
   input  logic [SET_W-1:0] set_i,
   output logic             monitor_o
);
   generate
      if (MON_W == 0) begin : g_none
         logic unused_set;
         assign unused_set = ^set_i;
         assign monitor_o  = 1'b0;
      end else begin : g_match
         assign monitor_o = (set_i[SET_W-1 -: MON_W] == set_i[MON_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/hgp_app_slot.sv
module hgp_app_slot
   import hgp_pkg::*;
#(
   parameter int AGE_W   = 4,
   parameter int APP_W   = 2,
   parameter int SLOT_ID = 0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             hit_valid_i,
   input  logic [APP_W-1:0] hit_app_i,
   input  logic [AGE_W-1:0] hit_age_i,
   input  logic             ivl_end_i,
   output logic [AGE_W-1:0] limit_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic [AGE_W-1:0] peak_q, limit_q, peak_d;
   logic             seen_q, seen_d, mine;
   dry_ph_t          ph_q;

   assign mine    = hit_valid_i && (hit_app_i == APP_W'(SLOT_ID));
   assign limit_o = limit_q;

   // Window state including a hit that arrives this cycle.
   always_comb begin
      peak_d = peak_q;
      seen_d = seen_q;
      if (mine) begin
         seen_d = 1'b1;
         if (hit_age_i > peak_q) peak_d = hit_age_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         peak_q  <= '0;
         seen_q  <= 1'b0;
         limit_q <= AGE_MAX;
         ph_q    <= PH_FED;
      end else if (ivl_end_i) begin
         peak_q <= '0;
         seen_q <= 1'b0;
         if (seen_d) begin
            limit_q <= (peak_d == AGE_MAX) ? AGE_MAX : peak_d + AGE_W'(1);
            ph_q    <= PH_FED;
         end else begin
            unique case (ph_q)
               PH_FED: begin
                  limit_q <= AGE_MAX;
                  ph_q    <= PH_DRY_ZERO;
               end
               PH_DRY_ZERO: begin
                  limit_q <= '0;
                  ph_q    <= PH_DRY_MAX;
               end
               default: begin
                  limit_q <= AGE_MAX;
                  ph_q    <= PH_DRY_ZERO;
               end
            endcase
         end
      end else begin
         peak_q <= peak_d;
         seen_q <= seen_d;
      end
   end
endmodule

// File: rtl/hitgap_predictor.sv
module hitgap_predictor #(
   parameter int NUM_APPS = 4,
   parameter int AGE_W    = 4,
   parameter int MISS_W   = 12,
   parameter int SET_W    = 12,
   parameter int MON_W    = 5,
   localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      miss_i,
   input  logic                      hit_valid_i,
   input  logic [APP_W-1:0]          hit_app_i,
   input  logic [AGE_W-1:0]          hit_age_i,
   input  logic [APP_W-1:0]          lkp_app_i,
   input  logic [SET_W-1:0]          lkp_set_i,
   output logic [AGE_W-1:0]          lkp_limit_o,
   output logic                      lkp_monitor_o,
   output logic [NUM_APPS*AGE_W-1:0] limit_vec_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   generate
      if (NUM_APPS < 1)         begin : g_bad_apps $error("NUM_APPS must be at least 1"); end
      if (AGE_W < 2 || AGE_W > 8) begin : g_bad_age $error("AGE_W must be 2..8"); end
      if (MISS_W < 1)           begin : g_bad_miss $error("MISS_W must be at least 1"); end
      if (SET_W < 2 * MON_W)    begin : g_bad_mon  $error("SET_W must be >= 2*MON_W"); end
   endgenerate

   logic ivl_end;
   logic mon_hit;
   logic [AGE_W-1:0] lim [NUM_APPS];

   hgp_interval_timer #(.MISS_W(MISS_W)) u_timer (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .miss_i   (miss_i),
      .ivl_end_o(ivl_end)
   );

   hgp_monitor_decode #(.SET_W(SET_W), .MON_W(MON_W)) u_mon (
      .set_i    (lkp_set_i),
      .monitor_o(mon_hit)
   );

   for (genvar a = 0; a < NUM_APPS; a++) begin : g_slot
      hgp_app_slot #(.AGE_W(AGE_W), .APP_W(APP_W), .SLOT_ID(a)) u_slot (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .hit_valid_i(hit_valid_i),
         .hit_app_i  (hit_app_i),
         .hit_age_i  (hit_age_i),
         .ivl_end_i  (ivl_end),
         .limit_o    (lim[a])
      );
      assign limit_vec_o[a*AGE_W +: AGE_W] = lim[a];
   end

   // Lookup: sampling sets see the maximum; an id past the last slot also does.
   always_comb begin
      lkp_limit_o = AGE_MAX;
      if (!mon_hit) begin
         for (int a = 0; a < NUM_APPS; a++) begin
            if (lkp_app_i == APP_W'(a)) lkp_limit_o = lim[a];
         end
      end
   end

   assign lkp_monitor_o = mon_hit;
endmodule

// File: rtl/hgp_checker.sv
module hgp_checker #(
   parameter int NUM_APPS = 4,
   parameter int AGE_W    = 4,
   parameter int MISS_W   = 12,
   parameter int APP_W    = 2
) (
   input logic                      clk_i,
   input logic                      rst_i,
   input logic                      miss_i,
   input logic [APP_W-1:0]          lkp_app_i,
   input logic [AGE_W-1:0]          lkp_limit_o,
   input logic                      lkp_monitor_o,
   input logic [NUM_APPS*AGE_W-1:0] limit_vec_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic [MISS_W-1:0] mcnt_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)       mcnt_q <= '0;
      else if (miss_i) mcnt_q <= mcnt_q + MISS_W'(1);
   end

   a_r1_reset_all_max: assert property (@(posedge clk_i)
      rst_i |=> (limit_vec_o == {NUM_APPS{AGE_MAX}}));

   a_r6_change_only_at_close: assert property (@(posedge clk_i) disable iff (rst_i)
      !(miss_i && (&mcnt_q)) |=> $stable(limit_vec_o));

   a_r8_monitor_gets_max: assert property (@(posedge clk_i) disable iff (rst_i)
      lkp_monitor_o |-> (lkp_limit_o == AGE_MAX));

   for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
      a_r8_normal_gets_app_limit: assert property (@(posedge clk_i) disable iff (rst_i)
         (!lkp_monitor_o && lkp_app_i == APP_W'(a))
            |-> (lkp_limit_o == limit_vec_o[a*AGE_W +: AGE_W]));

      a_r5_zero_only_after_max: assert property (@(posedge clk_i) disable iff (rst_i)
         (limit_vec_o[a*AGE_W +: AGE_W] != '0 && limit_vec_o[a*AGE_W +: AGE_W] != AGE_MAX)
            |=> (limit_vec_o[a*AGE_W +: AGE_W] != '0));
   end
endmodule

bind hitgap_predictor hgp_checker #(
   .NUM_APPS(NUM_APPS), .AGE_W(AGE_W), .MISS_W(MISS_W), .APP_W(APP_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .miss_i       (miss_i),
   .lkp_app_i    (lkp_app_i),
   .lkp_limit_o  (lkp_limit_o),
   .lkp_monitor_o(lkp_monitor_o),
   .limit_vec_o  (limit_vec_o)
);

// File: tb/hitgap_predictor_test.sv
`timescale 1ns/1ps
module hitgap_predictor_test;
   localparam int NA = 4, AW = 4, MW = 3, SW = 6, OW = 3;
   localparam int MAXV = (1 << AW) - 1;

   logic clk = 0, rst = 1;
   logic miss = 0, hv = 0;
   logic [1:0] happ = 0, lapp = 0;
   logic [AW-1:0] hage = 0;
   logic [SW-1:0] lset = 6'd10;
   logic [AW-1:0] llim;
   logic lmon;
   logic [NA*AW-1:0] lvec;

   always #2.5 clk = ~clk;

   hitgap_predictor #(.NUM_APPS(NA), .AGE_W(AW), .MISS_W(MW), .SET_W(SW), .MON_W(OW)) uut (
      .clk_i(clk), .rst_i(rst), .miss_i(miss), .hit_valid_i(hv), .hit_app_i(happ),
      .hit_age_i(hage), .lkp_app_i(lapp), .lkp_set_i(lset), .lkp_limit_o(llim),
      .lkp_monitor_o(lmon), .limit_vec_o(lvec));

   int nvec = 0, nbad = 0;
   bit done = 0;
   string tag = "R1";

   // Behavioural reference: 0 fed, 1 silent-next-zero, 2 silent-next-max.
   int m_lim[NA], m_pk[NA], m_seen[NA], m_ph[NA], m_cnt;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0;
         for (int a = 0; a < NA; a++) begin
            m_lim[a] = MAXV; m_pk[a] = 0; m_seen[a] = 0; m_ph[a] = 0;
         end
      end else begin
         if (hv) begin
            m_seen[happ] = 1;
            if (hage > m_pk[happ]) m_pk[happ] = hage;
         end
         if (miss) begin
            if (m_cnt == (1 << MW) - 1) begin
               for (int a = 0; a < NA; a++) begin
                  if (m_seen[a]) begin
                     m_lim[a] = (m_pk[a] + 1 > MAXV) ? MAXV : m_pk[a] + 1; m_ph[a] = 0;
                  end else if (m_ph[a] == 1) begin
                     m_lim[a] = 0; m_ph[a] = 2;
                  end else begin
                     m_lim[a] = MAXV; m_ph[a] = 1;
                  end
                  m_pk[a] = 0; m_seen[a] = 0;
               end
            end
            m_cnt = (m_cnt + 1) % (1 << MW);
         end
      end
   end

   task automatic check(string t, int act, int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   function automatic bit is_mon(int s);
      return ((s >> (SW - OW)) == (s & ((1 << OW) - 1)));
   endfunction

   always @(negedge clk) begin
      if (!rst && !done) begin
         for (int a = 0; a < NA; a++) check({tag, " limit"}, lvec[a*AW +: AW], m_lim[a]);
         check({tag, "/R8 monitor"}, lmon, is_mon(lset));
         check({tag, "/R8 lookup"}, llim, is_mon(lset) ? MAXV : m_lim[lapp]);
      end
   end

   task automatic step(bit v, int app, int age, bit m);
      hv = v; happ = 2'(app); hage = AW'(age); miss = m;
      @(posedge clk); #1;
      hv = 0; miss = 0;
   endtask

   task automatic misses(int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 1);
   endtask

   function automatic int lv(int a);
      return lvec[a*AW +: AW];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nbad++; nvec++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      check("R1 reset app0", lv(0), MAXV);
      rst = 0;
      @(posedge clk); #1;
      for (int a = 0; a < NA; a++) check("R1 after reset", lv(a), MAXV);

      // Window 1: app0 mixed ages, app1 near top, app2 at top, app3 silent.
      tag = "R2/R7";
      step(1, 0, 3, 0); step(1, 0, 7, 0); step(1, 0, 5, 1);
      step(1, 1, 14, 0); step(1, 2, 15, 1);
      misses(5);
      check("R6 before close app0", lv(0), MAXV);
      misses(1);
      check("R2 peak+1 app0", lv(0), 8);
      check("R7 app1", lv(1), 15);
      check("R3 saturate app2", lv(2), 15);
      check("R4 first silent app3", lv(3), MAXV);

      // Window 2: app0 single small hit, others silent.
      tag = "R5/R9";
      step(1, 0, 2, 0);
      misses(8);
      check("R9 fresh peak app0", lv(0), 3);
      check("R4 app1 first silent", lv(1), MAXV);
      check("R5 app3 goes zero", lv(3), 0);

      // Window 3: app0 age 0, app2 hit on the closing miss.
      step(1, 0, 0, 0);
      misses(7);
      step(1, 2, 6, 1);
      check("R2 age zero app0", lv(0), 1);
      check("R9 boundary hit app2", lv(2), 7);
      check("R5 app3 back to max", lv(3), MAXV);
      check("R5 app1 goes zero", lv(1), 0);

      // Lookups with app0 at limit 1.
      lapp = 0; lset = 6'd10; #1;
      check("R8 normal set", llim, 1);
      lset = 6'd9; #1;
      check("R8 monitor set 9", llim, MAXV);
      lset = 6'd0; #1;
      check("R8 monitor set 0 flag", lmon, 1);

      // Window 4: gapped misses, no hits.
      tag = "R6";
      for (int k = 0; k < 7; k++) begin step(0, 0, 0, 1); step(0, 0, 0, 0); step(0, 0, 0, 0); end
      check("R6 gapped before close", lv(0), 1);
      step(0, 0, 0, 1);
      check("R6 gapped close app0", lv(0), MAXV);
      check("R5 app3 zero again", lv(3), 0);

      // Random mix.
      tag = "R2/R5/R7/R8";
      for (int k = 0; k < 4000; k++) begin
         lapp = 2'($urandom_range(0, 3));
         lset = SW'($urandom_range(0, 63));
         if (($urandom % 3) == 0) begin
            int app = $urandom_range(0, 3);
            if (app == 3 && k > 1500) app = 2;
            step(1, app, $urandom_range(0, MAXV), ($urandom % 2) == 0);
         end else step(0, 0, 0, ($urandom % 2) == 0);
      end

      @(negedge clk); #1;
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule